// File: doc/BRIEF.md
# Upper Address Selector Register Bank

This block holds the two 32-bit selector registers that supply address bits 63:32 when a bus master runs a 64-bit cycle. The bus engine presents the type of cycle it is about to run, and the block returns at once the upper address half that belongs to that cycle type. One selector serves the data-write phase of memory-to-memory moves and absolute-address stores. The other serves instruction fetches and plain indirect fetches. Every other cycle type, including table-indirect fetches, gets an upper half of zero.

Software reaches both selectors through a simple register port. The port has a word offset, separate write and read strobes, and read data that is registered for one cycle. A 64-bit jump in the instruction stream can load the fetch selector directly, and this load takes priority over a software write in the same clock. A configuration-info enable input changes reads of the write selector so that they return the upper half of an external base address. The enable leaves writes alone, and reads return to the stored value as soon as it is cleared.

Top module: `uah_bank`

## Requirements
- R1: After reset both selectors hold zero, `reg_rdata` is zero, and `addr_hi` is zero for every cycle type.
- R2: A write strobe at word offset 0 stores `reg_wdata` into the write selector at that clock edge.
- R3: A write strobe at word offset 1 stores `reg_wdata` into the fetch selector at that clock edge.
- R4: With `cycle_type` 1 (move write) or 2 (absolute store), `addr_hi` equals the write selector in the same cycle.
- R5: With `cycle_type` 3 (script fetch) or 4 (indirect fetch), `addr_hi` equals the fetch selector in the same cycle.
- R6: With `cycle_type` 0 (idle), 5 (table-indirect fetch), 6 (move read) or 7 (unused), `addr_hi` is zero.
- R7: `jump_load` high at a clock edge loads `jump_target_hi` into the fetch selector.
- R8: When `jump_load` and a write at offset 1 fall in the same clock, the fetch selector takes `jump_target_hi`.
- R9: While `cfg_info_en` is high, a read at offset 0 returns `base_addr_hi`. A read at offset 1 still returns the fetch selector.
- R10: Writes made while `cfg_info_en` is high update the stored selector. Once the enable is low, a read at offset 0 returns the stored value.
- R11: `reg_rdata` takes the selected value at the edge where `reg_rd` is high and holds it while `reg_rd` is low. Reads at offsets 2 and 3 return zero, and writes there change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Word offset (0 write selector, 1 fetch selector) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| cfg_info_en | input | 1 | Read override enable for the write selector |
| base_addr_hi | input | 32 | Upper half of the base address returned under override |
| jump_load | input | 1 | 64-bit jump auto-load of the fetch selector |
| jump_target_hi | input | 32 | Upper target half loaded by a jump |
| cycle_type | input | 3 | Current bus cycle type code |
| addr_hi | output | 32 | Address bits 63:32 for the current cycle |

## Verification
The assertions assume that reset is asserted at the start, and that the strobes, offset, data and cycle type are driven to known values from then on. They also assume that a value shown on `base_addr_hi` or `jump_target_hi` is stable across the edge where it is used. The stimulus meets these assumptions by changing every input only on the falling clock edge and by keeping all inputs at defined levels from time zero. Writes and reads are issued as single-cycle strobe pulses.

// File: rtl/uah_pkg.sv
`timescale 1ns/1ps
package uah_pkg;
  localparam int DATA_W = 32;
  localparam int OFS_W  = 2;
  localparam int CT_W   = 3;

  localparam logic [OFS_W-1:0] OFS_WSEL = 2'd0;
  localparam logic [OFS_W-1:0] OFS_FSEL = 2'd1;

  typedef enum logic [CT_W-1:0] {
    CT_IDLE         = 3'd0,
    CT_MOVE_WR      = 3'd1,
    CT_ABS_STORE    = 3'd2,
    CT_SCRIPT_FETCH = 3'd3,
    CT_IND_FETCH    = 3'd4,
    CT_TBL_FETCH    = 3'd5,
    CT_MOVE_RD      = 3'd6,
    CT_RSVD         = 3'd7
  } cyc_type_e;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_WSEL = 2'd1,
    SRC_FSEL = 2'd2
  } sel_src_e;

  // Map a cycle type onto the selector that owns its upper address.
  function automatic sel_src_e route_cycle(logic [CT_W-1:0] ct);
    sel_src_e s;
    case (ct)
      CT_MOVE_WR, CT_ABS_STORE:      s = SRC_WSEL;
      CT_SCRIPT_FETCH, CT_IND_FETCH: s = SRC_FSEL;
      default:                       s = SRC_NONE;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/uah_sel_reg.sv
`timescale 1ns/1ps
module uah_sel_reg #(
  parameter int              W           = 32,
  parameter bit              HAS_HW_LOAD = 1'b0,
  parameter logic [W-1:0]    RESET_VAL   = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sw_we,
  input  logic [W-1:0] sw_data,
  input  logic         hw_load,
  input  logic [W-1:0] hw_data,
  output logic [W-1:0] q
);
  logic         hw_take;
  logic [W-1:0] q_d;

  // Hardware load overrides a software write in the same cycle.
  assign hw_take = HAS_HW_LOAD && hw_load;

  always_comb begin
    q_d = q;
    if (hw_take)    q_d = hw_data;
    else if (sw_we) q_d = sw_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RESET_VAL;
    else        q <= q_d;
  end

  generate
    if (HAS_HW_LOAD) begin : g_hw_chk
      AST_HW_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        hw_load |=> q == $past(hw_data)) else $error("hw load lost"); // R8
    end
  endgenerate

  AST_SEL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_we && !hw_take) |=> $stable(q)) else $error("selector changed without a write"); // R2
endmodule

// File: rtl/uah_read_port.sv
`timescale 1ns/1ps
module uah_read_port
  import uah_pkg::*;
#(
  parameter int W   = DATA_W,
  parameter int AW  = OFS_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd,
  input  logic [AW-1:0] addr,
  input  logic          cfg_en,
  input  logic [W-1:0]  base_hi,
  input  logic [W-1:0]  wsel_q,
  input  logic [W-1:0]  fsel_q,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    if (addr == OFS_WSEL)      rd_mux = cfg_en ? base_hi : wsel_q;
    else if (addr == OFS_FSEL) rd_mux = fsel_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (rd) rdata <= rd_mux;
  end

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(rdata)) else $error("rdata moved without read"); // R11

  AST_CFG_OVERRIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && cfg_en && addr == OFS_WSEL) |=> rdata == $past(base_hi))
    else $error("override read wrong"); // R9
endmodule

// File: rtl/uah_addr_mux.sv
`timescale 1ns/1ps
module uah_addr_mux
  import uah_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic [CT_W-1:0] cycle_type,
  input  logic [W-1:0]    wsel_q,
  input  logic [W-1:0]    fsel_q,
  output logic [W-1:0]    addr_hi
);
  sel_src_e src;

  assign src = route_cycle(cycle_type);

  always_comb begin
    case (src)
      SRC_WSEL: addr_hi = wsel_q;
      SRC_FSEL: addr_hi = fsel_q;
      default:  addr_hi = '0;
    endcase
  end
endmodule

// File: rtl/uah_bank.sv
`timescale 1ns/1ps
module uah_bank
  import uah_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [OFS_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              cfg_info_en,
  input  logic [DATA_W-1:0] base_addr_hi,
  input  logic              jump_load,
  input  logic [DATA_W-1:0] jump_target_hi,
  input  logic [CT_W-1:0]   cycle_type,
  output logic [DATA_W-1:0] addr_hi
);
  logic              wsel_we, fsel_we;
  logic [DATA_W-1:0] wsel_q, fsel_q;

  assign wsel_we = reg_wr && (reg_addr == OFS_WSEL);
  assign fsel_we = reg_wr && (reg_addr == OFS_FSEL);

  uah_sel_reg #(.W(DATA_W), .HAS_HW_LOAD(1'b0)) u_wsel (
    .clk(clk), .rst_n(rst_n),
    .sw_we(wsel_we), .sw_data(reg_wdata),
    .hw_load(1'b0), .hw_data('0),
    .q(wsel_q)
  );

  uah_sel_reg #(.W(DATA_W), .HAS_HW_LOAD(1'b1)) u_fsel (
    .clk(clk), .rst_n(rst_n),
    .sw_we(fsel_we), .sw_data(reg_wdata),
    .hw_load(jump_load), .hw_data(jump_target_hi),
    .q(fsel_q)
  );

  uah_read_port #(.W(DATA_W), .AW(OFS_W)) u_rport (
    .clk(clk), .rst_n(rst_n),
    .rd(reg_rd), .addr(reg_addr),
    .cfg_en(cfg_info_en), .base_hi(base_addr_hi),
    .wsel_q(wsel_q), .fsel_q(fsel_q),
    .rdata(reg_rdata)
  );

  uah_addr_mux #(.W(DATA_W)) u_amux (
    .cycle_type(cycle_type),
    .wsel_q(wsel_q), .fsel_q(fsel_q),
    .addr_hi(addr_hi)
  );

  AST_TBL_NO_FETCH_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_type == CT_TBL_FETCH) |-> addr_hi == '0) else $error("table fetch used selector"); // R6

  AST_WSEL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFS_WSEL && cycle_type == CT_MOVE_WR) |=>
      (cycle_type != CT_MOVE_WR || addr_hi == $past(reg_wdata)))
    else $error("write selector not loaded"); // R2

  AST_FSEL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFS_FSEL && !jump_load && cycle_type == CT_SCRIPT_FETCH) |=>
      (cycle_type != CT_SCRIPT_FETCH || addr_hi == $past(reg_wdata)))
    else $error("fetch selector not loaded"); // R3
endmodule

// File: tb/uah_bank_tb.sv
`timescale 1ns/1ps
module uah_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        cfg_info_en = 1'b0;
  logic [31:0] base_addr_hi = '0;
  logic        jump_load = 1'b0;
  logic [31:0] jump_target_hi = '0;
  logic [2:0]  cycle_type = '0;
  logic [31:0] addr_hi;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  uah_bank u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cfg_info_en(cfg_info_en), .base_addr_hi(base_addr_hi),
    .jump_load(jump_load), .jump_target_hi(jump_target_hi),
    .cycle_type(cycle_type), .addr_hi(addr_hi)
  );

  typedef struct packed {
    logic        wr;
    logic [1:0]  a;
    logic [31:0] d;
    logic [2:0]  ct;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t [0:NV-1] VEC = '{
    '{1'b1, 2'd0, 32'hA5A5_0001, 3'd1, 32'hA5A5_0001},  // R2 R4
    '{1'b1, 2'd1, 32'h0000_1234, 3'd3, 32'h0000_1234},  // R3 R5
    '{1'b0, 2'd0, 32'h0,         3'd2, 32'hA5A5_0001},  // R4
    '{1'b0, 2'd0, 32'h0,         3'd4, 32'h0000_1234},  // R5
    '{1'b0, 2'd0, 32'h0,         3'd5, 32'h0},          // R6
    '{1'b0, 2'd0, 32'h0,         3'd6, 32'h0},          // R6
    '{1'b0, 2'd0, 32'h0,         3'd0, 32'h0},          // R6
    '{1'b1, 2'd2, 32'hFFFF_FFFF, 3'd7, 32'h0},          // R6 R11
    '{1'b1, 2'd0, 32'hDEAD_BEEF, 3'd2, 32'hDEAD_BEEF},  // R2 R4
    '{1'b1, 2'd3, 32'h0000_0001, 3'd3, 32'h0000_1234}   // R11
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic do_read(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    #1 v = reg_rdata;
  endtask

  task automatic peek(input logic [2:0] ct, output logic [31:0] v);
    @(negedge clk);
    cycle_type = ct;
    #1 v = addr_hi;
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    // Reset state
    chk("R1 rdata", reg_rdata, 32'h0);
    peek(3'd1, v); chk("R1 addr_hi ct1", v, 32'h0);
    peek(3'd3, v); chk("R1 addr_hi ct3", v, 32'h0);
    rst_n = 1'b1;
    do_read(2'd0, v); chk("R1 wsel", v, 32'h0);
    do_read(2'd1, v); chk("R1 fsel", v, 32'h0);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      reg_wr = VEC[i].wr; reg_addr = VEC[i].a; reg_wdata = VEC[i].d;
      cycle_type = VEC[i].ct;
      @(negedge clk);
      reg_wr = 1'b0;
      #1 chk($sformatf("R4 R5 R6 vector %0d", i), addr_hi, VEC[i].exp);
    end

    // R11 unmapped offsets read zero, writes did not disturb selectors
    do_read(2'd2, v); chk("R11 ofs2 read", v, 32'h0);
    do_read(2'd3, v); chk("R11 ofs3 read", v, 32'h0);
    do_read(2'd0, v); chk("R2 R11 wsel readback", v, 32'hDEAD_BEEF);
    do_read(2'd1, v); chk("R3 R11 fsel readback", v, 32'h0000_1234);
    // R11 hold without read strobe
    @(negedge clk); reg_addr = 2'd1;
    repeat (2) @(negedge clk);
    #1 chk("R11 rdata hold", reg_rdata, 32'h0000_1234);

    // R7 jump load
    @(negedge clk); jump_load = 1'b1; jump_target_hi = 32'h0000_00FE;
    @(negedge clk); jump_load = 1'b0;
    peek(3'd3, v); chk("R7 jump load", v, 32'h0000_00FE);

    // R8 collision, jump wins
    @(negedge clk);
    jump_load = 1'b1; jump_target_hi = 32'h7777_0000;
    reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 32'h1111_2222;
    @(negedge clk);
    jump_load = 1'b0; reg_wr = 1'b0;
    peek(3'd4, v); chk("R8 jump beats write", v, 32'h7777_0000);

    // R9 override reads
    @(negedge clk); cfg_info_en = 1'b1; base_addr_hi = 32'hCAFE_0000;
    do_read(2'd0, v); chk("R9 override wsel", v, 32'hCAFE_0000);
    do_read(2'd1, v); chk("R9 fsel unaffected", v, 32'h7777_0000);
    // R10 write under override
    do_write(2'd0, 32'h0BAD_F00D);
    do_read(2'd0, v); chk("R10 still override", v, 32'hCAFE_0000);
    peek(3'd1, v); chk("R10 write landed", v, 32'h0BAD_F00D);
    @(negedge clk); cfg_info_en = 1'b0;
    do_read(2'd0, v); chk("R10 normal read", v, 32'h0BAD_F00D);

    // R1 reset again clears everything
    @(negedge clk); rst_n = 1'b0;
    #1 chk("R1 rdata after reset", reg_rdata, 32'h0);
    peek(3'd2, v); chk("R1 wsel after reset", v, 32'h0);
    peek(3'd3, v); chk("R1 fsel after reset", v, 32'h0);
    @(negedge clk); rst_n = 1'b1;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule